// File: doc/BRIEF.md
# Masked interrupt controller front end

This block sits between a vector of emulated peripheral interrupt request lines and the interrupt-pending input of an instruction dispatch unit. It catches each new request in a status register. It qualifies status with a mask register and a global enable held in a control register. The result is a single pending level, which is meant to feed bit 16 of the dispatch unit's status register.

The host reaches the three registers over a small synchronous register bus. Only a fixed set of mask positions can ever be written; the constant `0xF900008C` picks them out. Raw request lines 13 and 26 trade places on their way into status, so that the register view follows the emulated device numbering. A read of the control register acts as the acknowledge and drops the global enable.

Register map by `bus_addr`: 0 is status, 1 is mask, 2 is control, and 3 is reserved. Control holds the enable in bit 0, and its other bits read as zero. A bus cycle is a one-clock strobe with `bus_sel` high. When `bus_wr` is high the cycle is a write; otherwise, if `bus_rd` is high, it is a read. Write wins if both are set.

Top module: `irq_front`

## Requirements
- R1: After reset, status, mask and control are all zero, `irq_pending` is low and `bus_rdata` is zero.
- R2: A mask write stores `bus_wdata & 0xF900008C`, so writing all ones reads back as `0xF900008C`.
- R3: A status bit is set only on a low-to-high transition of its request line. A line held high does not set the bit again once it has been cleared.
- R4: Raw line 13 sets status bit 26 and raw line 26 sets status bit 13. Every other line N sets status bit N.
- R5: Writing status clears each bit that is 1 in `bus_wdata` and leaves the bits that are 0 untouched. A rising request in the same cycle keeps its bit set.
- R6: `irq_pending` is high exactly when control bit 0 is 1 and status AND mask is nonzero. It follows the register contents after each clock edge.
- R7: A control read returns the enable as it was before the read and then clears it. A control write loads the enable from `bus_wdata[0]`.
- R8: Read data is registered and appears in the cycle after the read strobe. `bus_rdata` is zero in the cycle after any clock without a read, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Raw peripheral request lines |
| bus_sel | input | 1 | Bus cycle strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pending | output | 1 | Qualified interrupt pending level |

## Verification
A request edge, a status or mask write, and a control write or read acknowledge each land in the registers at the first clock edge that samples them. `irq_pending` reflects that update in the same cycle. Read data belongs to the strobe of the previous clock, so it is compared one cycle after the read. The bench drives its inputs on the falling edge and computes the next register state from the values just driven. It compares `irq_pending` and `bus_rdata` at the following falling edge, which is exactly one rising edge later.

// File: rtl/irq_front.sv
module irq_front #(
  parameter int W = 32,
  parameter int AW = 2,
  parameter logic [W-1:0] WMASK = 32'hF900008C,
  parameter int SWAP_A = 13,
  parameter int SWAP_B = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  irq_in,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_pending
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);

  logic [W-1:0] irq_prev, status, mask, rise, rise_emu, rsel;
  logic en;

  assign rise = irq_in & ~irq_prev;

  always_comb begin
    rise_emu = rise;
    rise_emu[SWAP_A] = rise[SWAP_B];
    rise_emu[SWAP_B] = rise[SWAP_A];
  end

  wire wr_any  = bus_sel & bus_wr;
  wire rd_any  = bus_sel & bus_rd & ~bus_wr;
  wire wr_stat = wr_any & (bus_addr == A_STAT);
  wire wr_mask = wr_any & (bus_addr == A_MASK);
  wire wr_ctrl = wr_any & (bus_addr == A_CTRL);
  wire rd_ctrl = rd_any & (bus_addr == A_CTRL);

  always_comb begin
    case (bus_addr)
      A_STAT:  rsel = status;
      A_MASK:  rsel = mask;
      A_CTRL:  rsel = {{(W-1){1'b0}}, en};
      default: rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev  <= '0;
      status    <= '0;
      mask      <= '0;
      en        <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_prev  <= irq_in;
      status    <= (wr_stat ? (status & ~bus_wdata) : status) | rise_emu;
      if (wr_mask) mask <= bus_wdata & WMASK;
      if (wr_ctrl) en <= bus_wdata[0];
      else if (rd_ctrl) en <= 1'b0;
      bus_rdata <= rd_any ? rsel : '0;
    end
  end

  assign irq_pending = en & (|(status & mask));

  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (mask & ~WMASK) == '0); // R2
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_emu != '0) |=> ((status & $past(rise_emu)) == $past(rise_emu))); // R3
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && rise_emu == '0) |=> ((status & $past(bus_wdata)) == '0)); // R5
  AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq_pending |-> en); // R6
  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n) rd_ctrl |=> !en); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rd_any |=> bus_rdata == '0); // R8
endmodule

// File: tb/irq_front_test.sv
module irq_front_test;
  localparam logic [31:0] WM = 32'hF900008C;
  logic clk = 0, rst_n = 0;
  logic [31:0] irq_in = 0, bus_wdata = 0, bus_rdata;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0, irq_pending;
  logic [1:0] bus_addr = 0;
  int checks = 0, failures = 0;

  logic [31:0] m_stat = 0, m_mask = 0, m_prev = 0, m_rd = 0;
  logic m_en = 0;
  string rtag = "R8";

  irq_front uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pending(irq_pending));

  always #10 clk = ~clk;

  function automatic logic [31:0] swp(logic [31:0] v);
    logic [31:0] r = v;
    r[13] = v[26];
    r[26] = v[13];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic w, logic r, logic [1:0] a, logic [31:0] d, logic [31:0] irq);
    logic rd_any, wr_any;
    bus_sel = s; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; irq_in = irq;
    rd_any = s & r & ~w;
    wr_any = s & w;
    if (rd_any) begin
      case (a)
        2'd0: begin m_rd = m_stat; rtag = "R5"; end
        2'd1: begin m_rd = m_mask; rtag = "R2"; end
        2'd2: begin m_rd = {31'b0, m_en}; rtag = "R7"; end
        default: begin m_rd = 0; rtag = "R8"; end
      endcase
    end else begin
      m_rd = 0; rtag = "R8";
    end
    m_stat = ((wr_any && a == 2'd0) ? (m_stat & ~d) : m_stat) | swp(irq & ~m_prev);
    if (wr_any && a == 2'd1) m_mask = d & WM;
    if (wr_any && a == 2'd2) m_en = d[0];
    else if (rd_any && a == 2'd2) m_en = 0;
    m_prev = irq;
    @(negedge clk);
    chk("R6", {31'b0, irq_pending}, {31'b0, m_en & (|(m_stat & m_mask))});
    chk(rtag, bus_rdata, m_rd);
  endtask

  task automatic rdx(logic [1:0] a, logic [31:0] exp, string tag);
    cyc(1, 0, 1, a, 0, irq_in);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] irq;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {31'b0, irq_pending}, 0);
    chk("R1", bus_rdata, 0);
    rdx(0, 0, "R1"); rdx(1, 0, "R1"); rdx(2, 0, "R1");
    cyc(1, 1, 0, 1, 32'hFFFFFFFF, 0);
    rdx(1, 32'hF900008C, "R2");
    cyc(0, 0, 0, 0, 0, 32'h1 << 13);
    rdx(0, 32'h1 << 26, "R4");
    cyc(1, 1, 0, 0, 32'h1 << 26, irq_in);
    rdx(0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 32'h1 << 26);
    rdx(0, 32'h1 << 13, "R4");
    cyc(1, 1, 0, 0, 32'h1 << 13, 32'h8);
    rdx(0, 32'h8, "R5");
    cyc(1, 1, 0, 0, 0, 32'h8);
    rdx(0, 32'h8, "R5");
    cyc(1, 1, 0, 0, 32'h8, 32'h8);
    cyc(0, 0, 0, 0, 0, 32'h8);
    rdx(0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 32'h8);
    chk("R6", {31'b0, irq_pending}, 0);
    cyc(1, 1, 0, 2, 32'h1, 32'h8);
    chk("R6", {31'b0, irq_pending}, 1);
    rdx(2, 1, "R7");
    chk("R7", {31'b0, irq_pending}, 0);
    rdx(2, 0, "R7");
    rdx(3, 0, "R8");
    cyc(1, 1, 0, 2, 32'h1, 32'h8);
    cyc(1, 1, 0, 0, 32'h8, 32'h8);
    chk("R6", {31'b0, irq_pending}, 0);
    irq = irq_in;
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      irq = irq ^ ($urandom & $urandom & $urandom);
      case (op)
        3'd0: cyc(1, 1, 0, 2'($urandom_range(0, 3)), $urandom, irq);
        3'd1: cyc(1, 0, 1, 2'($urandom_range(0, 3)), 0, irq);
        3'd2: cyc(1, 1, 1, 2'($urandom_range(0, 3)), $urandom, irq);
        3'd3: cyc(1, 1, 0, 2'd2, 32'h1, irq);
        default: cyc(0, 1'($urandom), 1'($urandom), 2'($urandom_range(0, 3)), $urandom, irq);
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule